// File: doc/BRIEF.md
# Multi-master I2C byte transfer engine

This block is the byte-level master side of an I2C controller for a bus shared with other masters. A host gives it one command at a time: START, WRITE a byte, READ a byte, or STOP. The engine drives SCL and SDA as open-drain pull-down enables and reads back the resolved line levels. After each byte it runs a ninth clock for the acknowledge. On a write it samples the acknowledge from the slave. On a read it returns ACK or NACK as the host selects. The host uses NACK on the final byte of a read.

The SCL timing comes from an external clock generator as a `tick_i` strobe, and the engine advances one step per tick. Each data bit takes four steps: place SDA, release SCL, sample while SCL is high, pull SCL low. The sample step does not advance until the wired SCL line is actually high. A line monitor watches for START and STOP conditions from any master, and it keeps a bus-free flag. A fresh START waits on that flag.

During a write, every bit the engine leaves high is compared with the line. If the line reads low, another master has won the bus. The engine then releases both lines, sets a sticky arbitration-lost flag and ends the command without a STOP.

Top module: `i2c_mm_engine`

## Requirements
- R1: After reset both pull-down enables are 0, `busy_o`, `done_o` and `arb_lost_o` are 0, and `bus_free_o` is 1.
- R2: START takes four ticks: release SDA, release SCL, pull SDA low once SCL is high, pull SCL low. It leaves the engine owning the bus with both lines held low. If the engine already owns the bus, the same steps form a repeated START.
- R3: A START issued while the engine does not own the bus and `bus_free_o` is 0 makes no change on the lines, however many ticks arrive, until a STOP is seen on the bus.
- R4: `bus_free_o` goes to 0 one cycle after SDA falls while SCL stays high. It goes to 1 one cycle after SDA rises while SCL stays high.
- R5: WRITE sends the 8 bits MSB first. A 0 bit sets `sda_oe_o` to 1 (pull low) and a 1 bit sets it to 0. SDA changes only while SCL is pulled low.
- R6: On the ninth clock of a WRITE, SDA is released. `ack_o` becomes 1 if SDA was sampled low and 0 if it was sampled high.
- R7: READ leaves SDA released for 8 bits, shifts the sampled levels in MSB first, and presents the byte on `rdata_o` at the end of the command.
- R8: On the ninth clock of a READ, the engine pulls SDA low when `rd_nack_i` was 0 at command time, and releases it when `rd_nack_i` was 1.
- R9: STOP takes three ticks: pull SDA low, release SCL, then release SDA once SCL is high. It leaves both lines released and gives up ownership.
- R10: If a WRITE data bit is released but SDA reads low while SCL is high, then in that same cycle `arb_lost_o` rises, both enables drop to 0 and `done_o` pulses, with no STOP. `arb_lost_o` stays set until the next START is accepted.
- R11: One bit takes four ticks in the order place SDA, release SCL, sample, pull SCL low. The sample step waits until SCL reads high.
- R12: A command is accepted in a cycle with `cmd_valid_i` high and `busy_o` low. The encodings are 0 START, 1 WRITE, 2 READ, 3 STOP. `busy_o` is high from the next cycle until the cycle of the one-cycle `done_o` pulse, and `cmd_valid_i` is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Step strobe from the SCL clock generator |
| cmd_valid_i | input | 1 | Command request |
| cmd_i | input | 2 | Command code (0 START, 1 WRITE, 2 READ, 3 STOP) |
| wdata_i | input | 8 | Byte to send with WRITE |
| rd_nack_i | input | 1 | READ: 1 to NACK the byte, 0 to ACK |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle pulse when a command ends |
| rdata_o | output | 8 | Last byte received |
| ack_o | output | 1 | Acknowledge sampled after the last WRITE |
| arb_lost_o | output | 1 | Sticky arbitration-lost flag |
| bus_free_o | output | 1 | No transfer on the bus |
| sda_oe_o | output | 1 | Pull SDA low |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_i | input | 1 | Resolved SDA level |
| scl_i | input | 1 | Resolved SCL level |

## Verification
The bench models the wired-AND bus with a slave and a second master. It goes after these corner cases:
- Acknowledges in both polarities. A design that drove SDA on the write acknowledge would hide a slave NACK.
- A read ending in NACK. A design that always acknowledged would keep the slave transmitting.
- A second master pulling a released bit low. A design without the bit check would keep driving, and one that issued a STOP after losing would corrupt the winner's frame.
- A START requested while another master holds the bus. A design that ignored the bus-free flag would emit a START into that transfer.
- A command pulsed mid-byte. A design that accepted it would break the bit sequence.

// File: rtl/i2c_mm_pkg.sv
package i2c_mm_pkg;
  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_READ  = 2'd2,
    CMD_STOP  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_STOP,
    ST_BIT
  } state_e;

  // order is the per-bit sequence
  typedef enum logic [1:0] {
    PH_SET,
    PH_RISE,
    PH_SAMPLE,
    PH_FALL
  } phase_e;
endpackage

// File: rtl/i2c_mm_bus_mon.sv
module i2c_mm_bus_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_i,
  output logic bus_free_o
);
  logic sda_q, scl_q;
  logic start_det, stop_det;

  assign start_det = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_det  = scl_q & scl_i & ~sda_q & sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q      <= 1'b1;
      scl_q      <= 1'b1;
      bus_free_o <= 1'b1;
    end else begin
      sda_q <= sda_i;
      scl_q <= scl_i;
      if (start_det)     bus_free_o <= 1'b0;
      else if (stop_det) bus_free_o <= 1'b1;
    end
  end

  AST_FREE_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_q && scl_i && !sda_q && sda_i) |=> bus_free_o); // R4
  AST_TAKEN_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_q && scl_i && sda_q && !sda_i) |=> !bus_free_o); // R4
endmodule

// File: rtl/i2c_mm_shift.sv
module i2c_mm_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              shift_i,
  input  logic              in_bit_i,
  output logic              msb_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (load_i)  data_o <= load_val_i;
    else if (shift_i) data_o <= {data_o[DATA_W-2:0], in_bit_i};
  end

  assign msb_o = data_o[DATA_W-1];
endmodule

// File: rtl/i2c_mm_ctrl.sv
module i2c_mm_ctrl
  import i2c_mm_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic              rd_nack_i,
  input  logic              bus_free_i,
  input  logic              sda_i,
  input  logic              scl_i,
  input  logic              shift_msb_i,
  input  logic [DATA_W-1:0] shift_data_i,
  output logic              shift_load_o,
  output logic              shift_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ack_o,
  output logic              arb_lost_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sda_oe_o,
  output logic              scl_oe_o
);
  state_e           st_q;
  phase_e           ph_q;
  logic [1:0]       step_q;
  logic [CNT_W-1:0] bit_q;
  logic             is_rd_q, nack_q, own_q;
  logic             accept, last_bit, samp, arb_hit;

  assign accept   = cmd_valid_i && (st_q == ST_IDLE);
  assign last_bit = (bit_q == CNT_W'(DATA_W));
  assign samp     = (st_q == ST_BIT) && tick_i && (ph_q == PH_SAMPLE) && scl_i;
  // released data bit seen low: another master owns the bus
  assign arb_hit  = samp && !is_rd_q && !last_bit && !sda_oe_o && !sda_i;

  assign busy_o       = (st_q != ST_IDLE);
  assign shift_load_o = accept && (cmd_e'(cmd_i) == CMD_WRITE);
  assign shift_en_o   = samp && !last_bit && !arb_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ph_q       <= PH_SET;
      step_q     <= '0;
      bit_q      <= '0;
      is_rd_q    <= 1'b0;
      nack_q     <= 1'b0;
      own_q      <= 1'b0;
      sda_oe_o   <= 1'b0;
      scl_oe_o   <= 1'b0;
      done_o     <= 1'b0;
      ack_o      <= 1'b0;
      arb_lost_o <= 1'b0;
      rdata_o    <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (cmd_valid_i) begin
          step_q <= '0;
          ph_q   <= PH_SET;
          bit_q  <= '0;
          unique case (cmd_e'(cmd_i))
            CMD_START: begin st_q <= ST_START; arb_lost_o <= 1'b0; end
            CMD_WRITE: begin st_q <= ST_BIT; is_rd_q <= 1'b0; end
            CMD_READ:  begin st_q <= ST_BIT; is_rd_q <= 1'b1; nack_q <= rd_nack_i; end
            CMD_STOP:  st_q <= ST_STOP;
          endcase
        end
        ST_START: if (tick_i) begin
          unique case (step_q)
            2'd0: if (own_q || bus_free_i) begin sda_oe_o <= 1'b0; step_q <= 2'd1; end
            2'd1: begin scl_oe_o <= 1'b0; step_q <= 2'd2; end
            2'd2: if (scl_i) begin sda_oe_o <= 1'b1; step_q <= 2'd3; end
            2'd3: begin
              scl_oe_o <= 1'b1;
              own_q    <= 1'b1;
              done_o   <= 1'b1;
              st_q     <= ST_IDLE;
            end
          endcase
        end
        ST_STOP: if (tick_i) begin
          unique case (step_q)
            2'd0: begin sda_oe_o <= 1'b1; step_q <= 2'd1; end
            2'd1: begin scl_oe_o <= 1'b0; step_q <= 2'd2; end
            default: if (scl_i) begin
              sda_oe_o <= 1'b0;
              own_q    <= 1'b0;
              done_o   <= 1'b1;
              st_q     <= ST_IDLE;
            end
          endcase
        end
        ST_BIT: if (tick_i) begin
          unique case (ph_q)
            PH_SET: begin
              sda_oe_o <= last_bit ? (is_rd_q && !nack_q) : (!is_rd_q && !shift_msb_i);
              ph_q     <= PH_RISE;
            end
            PH_RISE: begin scl_oe_o <= 1'b0; ph_q <= PH_SAMPLE; end
            PH_SAMPLE: if (scl_i) begin
              if (arb_hit) begin
                sda_oe_o   <= 1'b0;
                scl_oe_o   <= 1'b0;
                own_q      <= 1'b0;
                arb_lost_o <= 1'b1;
                done_o     <= 1'b1;
                st_q       <= ST_IDLE;
              end else begin
                if (!is_rd_q && last_bit) ack_o <= !sda_i;
                ph_q <= PH_FALL;
              end
            end
            PH_FALL: begin
              scl_oe_o <= 1'b1;
              if (last_bit) begin
                if (is_rd_q) rdata_o <= shift_data_i;
                done_o <= 1'b1;
                st_q   <= ST_IDLE;
              end else begin
                bit_q <= bit_q + CNT_W'(1);
                ph_q  <= PH_SET;
              end
            end
          endcase
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_ARB_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arb_lost_o) |-> (!sda_oe_o && !scl_oe_o && done_o)); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R12
  AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BIT && $past(st_q) == ST_BIT && $past(!scl_oe_o) && !scl_oe_o)
      |-> $stable(sda_oe_o)); // R5
  AST_WR_ACK_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BIT && !is_rd_q && last_bit && ph_q != PH_SET) |-> !sda_oe_o); // R6
endmodule

// File: rtl/i2c_mm_engine.sv
module i2c_mm_engine #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_nack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o,
  output logic              arb_lost_o,
  output logic              bus_free_o,
  output logic              sda_oe_o,
  output logic              scl_oe_o,
  input  logic              sda_i,
  input  logic              scl_i
);
  logic              sh_load, sh_en, sh_msb;
  logic [DATA_W-1:0] sh_data;

  i2c_mm_bus_mon u_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_i),
    .scl_i      (scl_i),
    .bus_free_o (bus_free_o)
  );

  i2c_mm_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sh_load),
    .load_val_i (wdata_i),
    .shift_i    (sh_en),
    .in_bit_i   (sda_i),
    .msb_o      (sh_msb),
    .data_o     (sh_data)
  );

  i2c_mm_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_i        (cmd_i),
    .rd_nack_i    (rd_nack_i),
    .bus_free_i   (bus_free_o),
    .sda_i        (sda_i),
    .scl_i        (scl_i),
    .shift_msb_i  (sh_msb),
    .shift_data_i (sh_data),
    .shift_load_o (sh_load),
    .shift_en_o   (sh_en),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .ack_o        (ack_o),
    .arb_lost_o   (arb_lost_o),
    .rdata_o      (rdata_o),
    .sda_oe_o     (sda_oe_o),
    .scl_oe_o     (scl_oe_o)
  );

  AST_RESET_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!sda_oe_o && !scl_oe_o)); // R1
endmodule

// File: tb/sim_i2c_mm_engine.sv
module sim_i2c_mm_engine;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_ni, tick, cmd_valid, rd_nack;
  logic [1:0] cmd;
  logic [7:0] wdata;
  logic       busy, done, ack, arb_lost, bus_free, sda_oe, scl_oe;
  logic [7:0] rdata;
  logic       slave_pull = 1'b0, oth_sda = 1'b0;
  logic       sda_w, scl_w;

  assign sda_w = !(sda_oe | slave_pull | oth_sda);
  assign scl_w = !scl_oe;

  i2c_mm_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .cmd_valid_i(cmd_valid),
    .cmd_i(cmd), .wdata_i(wdata), .rd_nack_i(rd_nack), .busy_o(busy),
    .done_o(done), .rdata_o(rdata), .ack_o(ack), .arb_lost_o(arb_lost),
    .bus_free_o(bus_free), .sda_oe_o(sda_oe), .scl_oe_o(scl_oe),
    .sda_i(sda_w), .scl_i(scl_w)
  );

  int  n_chk = 0, n_fail = 0, cyc = 0;
  bit  chk_en = 1'b0;
  logic exp_scl = 0, exp_sda = 0, exp_busy = 0, exp_done = 0, exp_arb = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // per-clock comparison against the behavioural model
  always @(posedge clk) if (chk_en) begin
    #1;
    check("R11 scl_oe", 32'(scl_oe), 32'(exp_scl));
    check("R5 sda_oe", 32'(sda_oe), 32'(exp_sda));
    check("R12 busy", 32'(busy), 32'(exp_busy));
    check("R12 done", 32'(done), 32'(exp_done));
    check("R10 arb_lost", 32'(arb_lost), 32'(exp_arb));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog actual=timeout expected=completion");
      summary();
    end
  end

  task automatic tk(input logic s, input logic d, input bit fin = 0, input bit lost = 0);
    @(negedge clk);
    tick = 1'b1; exp_scl = s; exp_sda = d;
    if (fin)  begin exp_done = 1'b1; exp_busy = 1'b0; end
    if (lost) exp_arb = 1'b1;
    @(negedge clk);
    tick = 1'b0; exp_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] c, input logic [7:0] b = 8'h00, input logic nk = 0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; wdata = b; rd_nack = nk; exp_busy = 1'b1;
    if (c == 2'd0) exp_arb = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_start();
    issue(2'd0);
    tk(exp_scl, 1'b0); tk(1'b0, 1'b0); tk(1'b0, 1'b1); tk(1'b1, 1'b1, 1);
  endtask

  task automatic do_stop();
    issue(2'd3);
    tk(1'b1, 1'b1); tk(1'b0, 1'b1); tk(1'b0, 1'b0, 1);
    check("R9 lines released", 32'({sda_oe, scl_oe}), 32'h0);
  endtask

  task automatic write_bits(input logic [7:0] b, input bit sl_ack);
    for (int i = 7; i >= 0; i--) begin
      tk(1'b1, !b[i]); tk(1'b0, !b[i]); tk(1'b0, !b[i]); tk(1'b1, !b[i]);
    end
    slave_pull = sl_ack;
    tk(1'b1, 1'b0); tk(1'b0, 1'b0); tk(1'b0, 1'b0); tk(1'b1, 1'b0, 1);
    slave_pull = 1'b0;
    check("R6 ack_o", 32'(ack), 32'(sl_ack));
  endtask

  task automatic do_read(input logic [7:0] b, input logic nk);
    issue(2'd2, 8'h00, nk);
    for (int i = 7; i >= 0; i--) begin
      slave_pull = !b[i];
      tk(1'b1, 1'b0); tk(1'b0, 1'b0); tk(1'b0, 1'b0); tk(1'b1, 1'b0);
    end
    slave_pull = 1'b0;
    tk(1'b1, !nk); tk(1'b0, !nk);
    check("R8 ack drive", 32'(sda_oe), 32'(!nk));
    tk(1'b0, !nk); tk(1'b1, !nk, 1);
    check("R7 rdata", 32'(rdata), 32'(b));
  endtask

  initial begin
    rst_ni = 0; tick = 0; cmd_valid = 0; cmd = 0; wdata = 0; rd_nack = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check("R1 enables", 32'({sda_oe, scl_oe}), 32'h0);
    check("R1 flags", 32'({busy, done, arb_lost}), 32'h0);
    check("R1 bus_free", 32'(bus_free), 32'h1);
    chk_en = 1'b1;

    // frame: start, writes with ack and nack, repeated start, reads, stop
    do_start();
    check("R2 lines held", 32'({sda_oe, scl_oe}), 32'h3);
    check("R4 taken", 32'(bus_free), 32'h0);
    issue(2'd1, 8'hA5);
    // R12: request while busy must be ignored
    @(negedge clk); cmd_valid = 1'b1; cmd = 2'd3;
    @(negedge clk); cmd_valid = 1'b0;
    write_bits(8'hA5, 1);
    issue(2'd1, 8'h3C); write_bits(8'h3C, 0);
    do_start();
    issue(2'd1, 8'h81); write_bits(8'h81, 1);
    do_read(8'h96, 0);
    do_read(8'h5A, 1);
    do_stop();
    repeat (2) @(negedge clk);
    check("R4 free", 32'(bus_free), 32'h1);

    // R10: second master wins on bit 6
    do_start();
    issue(2'd1, 8'h40);
    tk(1'b1, 1'b1); tk(1'b0, 1'b1); tk(1'b0, 1'b1); tk(1'b1, 1'b1);
    oth_sda = 1'b1;
    tk(1'b1, 1'b0); tk(1'b0, 1'b0); tk(1'b0, 1'b0, 1, 1);
    repeat (3) @(negedge clk);
    check("R10 released", 32'({sda_oe, scl_oe}), 32'h0);
    check("R10 no stop", 32'(bus_free), 32'h0);
    oth_sda = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 other stop", 32'(bus_free), 32'h1);

    // R3: start requested while another master holds the bus
    oth_sda = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 other start", 32'(bus_free), 32'h0);
    issue(2'd0);
    tk(1'b0, 1'b0); tk(1'b0, 1'b0); tk(1'b0, 1'b0);
    check("R3 waiting", 32'({sda_oe, scl_oe, busy}), 32'h1);
    check("R10 cleared", 32'(arb_lost), 32'h0);
    oth_sda = 1'b0;
    repeat (3) @(negedge clk);
    tk(1'b0, 1'b0); tk(1'b0, 1'b0); tk(1'b0, 1'b1); tk(1'b1, 1'b1, 1);
    check("R2 start after wait", 32'(bus_free), 32'h0);
    issue(2'd1, 8'hFF); write_bits(8'hFF, 1);
    do_stop();
    repeat (4) @(negedge clk);
    chk_en = 1'b0;
    check("R9 bus free", 32'(bus_free), 32'h1);
    summary();
  end
endmodule